// File: doc/BRIEF.md
# Paired-Bank Register Address Pointer

This block keeps the internal address pointer of a register file of 22 registers, built as 11 pairs with one member serving port A and one serving port B. A serial front end loads the pointer with the address taken from a command and pulses a strobe after each data byte. The block turns the pointer into a physical register index and, between strobes, moves the pointer to the next address according to a burst mode.

Two address layouts exist. In the paired layout the two members of a pair sit at neighbouring addresses, A even and B odd. In the split layout all port A registers come first, from 00h, and all port B registers start at 10h. The layout bit is captured only when the pointer is loaded, so a layout change never disturbs a burst that is already running. The mode input picks sequential bursts, where the pointer counts up and wraps to 00h after the last register, or single-register bursts, where it holds. A single-register burst in the paired layout instead swaps between the A and B members of the current pair.

The physical index is `2*pair + port` (port A = 0, port B = 1). Addresses that hold no register report a miss with index zero, and downstream logic reads those as zero and drops writes. Index, hit flag and pointer are all registered.

Top module: `reg_ptr_top`

## Requirements
- R1: A synchronous reset sets the pointer to 00h, the captured layout to paired (0), and the outputs to index 0 with hit = 1.
- R2: A load (`ptr_ld` = 1) writes `ptr_ld_addr` into the pointer and captures `layout_in`; a load in the same cycle as a byte strobe wins and the strobe is ignored.
- R3: In the paired layout (layout = 0) an address a below 22 maps to index a with hit = 1; for example 12h gives index 18 and 13h gives index 19.
- R4: In the split layout (layout = 1) address a in 00h..0Ah maps to index 2a, and address a in 10h..1Ah maps to index 2(a-10h)+1, both with hit = 1.
- R5: Addresses without a register give hit = 0 and index 0: 16h..1Fh in the paired layout, 0Bh..0Fh and 1Bh..1Fh in the split layout.
- R6: The configuration pair (pair 5) is reached at 0Ah/0Bh in the paired layout and at 05h/15h in the split layout, giving index 10 for A and 11 for B in both.
- R7: With `byte_mode` = 0 in the paired layout, each strobe adds one to the pointer, and a strobe at 15h or above returns it to 00h.
- R8: With `byte_mode` = 0 in the split layout, each strobe adds one, passing through the empty addresses 0Bh..0Fh, and a strobe at 1Ah or above returns it to 00h.
- R9: With `byte_mode` = 1 in the split layout, a strobe leaves the pointer unchanged.
- R10: With `byte_mode` = 1 in the paired layout, a strobe inverts bit 0 of the pointer, alternating between the members of the pair whichever one it started on.
- R11: A change of `layout_in` without a load has no effect on the pointer update or the mapping until the next load.
- R12: `byte_mode` is sampled at every strobe, so a burst can switch between counting and holding/toggling; a low level (the cleared configuration value) means sequential.
- R13: With neither load nor strobe the pointer and outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_ld | input | 1 | Load the pointer from ptr_ld_addr |
| ptr_ld_addr | input | ADDR_W (5) | Address to load |
| byte_done | input | 1 | One data byte finished; advance the pointer |
| layout_in | input | 1 | Layout bit, 0 paired, 1 split; captured on load |
| byte_mode | input | 1 | 1 single-register bursts, 0 sequential |
| ptr_q | output | ADDR_W (5) | Current pointer value |
| reg_idx | output | IDX_W (5) | Physical register index, 0 on a miss |
| reg_hit | output | 1 | Pointer addresses an existing register |

## Verification
The bench builds the block with its defaults, 11 pairs and a 5-bit pointer, so the whole 32-entry address space fits in a sweep: every address is loaded under both layouts and compared with index values derived arithmetically from the layout rules, which covers every empty hole. Full sequential walks of more than one lap in each layout reach both wrap points and the split-layout gap, while single-register bursts started on even and odd addresses exercise holding and pair swapping. Directed cases cover a layout change mid-burst, a load colliding with a strobe, idle cycles and a mode switch inside a burst.

// File: rtl/reg_ptr_pkg.sv
package reg_ptr_pkg;
  typedef enum logic {
    LAYOUT_PAIRED = 1'b0,
    LAYOUT_SPLIT  = 1'b1
  } layout_e;

  typedef enum logic [1:0] {
    STEP_HOLD,
    STEP_SWAP,
    STEP_INCR,
    STEP_WRAP
  } step_kind_e;
endpackage

// File: rtl/reg_ptr_step.sv
module reg_ptr_step
  import reg_ptr_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int LAST_PAIRED = 21,
  parameter int LAST_SPLIT  = 26
) (
  input  logic [ADDR_W-1:0] cur,
  input  layout_e           layout,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] LastP = ADDR_W'(LAST_PAIRED);
  localparam logic [ADDR_W-1:0] LastS = ADDR_W'(LAST_SPLIT);

  logic [ADDR_W-1:0] last_addr;
  step_kind_e        kind;

  always_comb begin
    last_addr = (layout == LAYOUT_SPLIT) ? LastS : LastP;
    if (byte_mode)
      kind = (layout == LAYOUT_SPLIT) ? STEP_HOLD : STEP_SWAP;
    else
      kind = (cur >= last_addr) ? STEP_WRAP : STEP_INCR;
  end

  always_comb begin
    unique case (kind)
      STEP_HOLD: nxt = cur;
      STEP_SWAP: nxt = {cur[ADDR_W-1:1], ~cur[0]};
      STEP_INCR: nxt = cur + 1'b1;
      default:   nxt = '0;
    endcase
  end
endmodule

// File: rtl/reg_ptr_map.sv
module reg_ptr_map
  import reg_ptr_pkg::*;
#(
  parameter int NUM_PAIRS = 11,
  parameter int HALF_W    = 4,
  parameter int ADDR_W    = HALF_W + 1,
  parameter int IDX_W     = HALF_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  layout_e           layout,
  output logic [IDX_W-1:0]  idx,
  output logic              hit
);
  localparam int NUM_REGS = 2 * NUM_PAIRS;

  logic [HALF_W-1:0] half_off;
  logic              split_port;
  logic              hit_p, hit_s;

  always_comb begin
    half_off   = addr[HALF_W-1:0];
    split_port = addr[ADDR_W-1];
    hit_p      = ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS));
    hit_s      = ({1'b0, half_off} < (HALF_W+1)'(NUM_PAIRS));
    if (layout == LAYOUT_SPLIT) begin
      hit = hit_s;
      idx = hit_s ? IDX_W'({half_off, split_port}) : '0;
    end else begin
      hit = hit_p;
      idx = hit_p ? IDX_W'(addr) : '0;
    end
  end
endmodule

// File: rtl/reg_ptr_top.sv
module reg_ptr_top
  import reg_ptr_pkg::*;
#(
  parameter int NUM_PAIRS = 11,
  parameter int HALF_W    = $clog2(NUM_PAIRS),
  parameter int ADDR_W    = HALF_W + 1,
  parameter int IDX_W     = HALF_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_ld_addr,
  input  logic              byte_done,
  input  logic              layout_in,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] ptr_q,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_hit
);
  localparam int SPLIT_BASE  = 2 ** HALF_W;
  localparam int LAST_PAIRED = 2 * NUM_PAIRS - 1;
  localparam int LAST_SPLIT  = SPLIT_BASE + NUM_PAIRS - 1;

  layout_e           lay_q, lay_d;
  logic [ADDR_W-1:0] ptr_d, step_nxt;
  logic [IDX_W-1:0]  idx_d;
  logic              hit_d;

  reg_ptr_step #(
    .ADDR_W(ADDR_W), .LAST_PAIRED(LAST_PAIRED), .LAST_SPLIT(LAST_SPLIT)
  ) u_step (
    .cur(ptr_q), .layout(lay_q), .byte_mode(byte_mode), .nxt(step_nxt)
  );

  always_comb begin
    if (ptr_ld) begin
      ptr_d = ptr_ld_addr;
      lay_d = layout_e'(layout_in);
    end else if (byte_done) begin
      ptr_d = step_nxt;
      lay_d = lay_q;
    end else begin
      ptr_d = ptr_q;
      lay_d = lay_q;
    end
  end

  reg_ptr_map #(
    .NUM_PAIRS(NUM_PAIRS), .HALF_W(HALF_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_map (
    .addr(ptr_d), .layout(lay_d), .idx(idx_d), .hit(hit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      lay_q   <= LAYOUT_PAIRED;
      reg_idx <= '0;
      reg_hit <= 1'b1;
    end else begin
      ptr_q   <= ptr_d;
      lay_q   <= lay_d;
      reg_idx <= idx_d;
      reg_hit <= hit_d;
    end
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_ld |=> ptr_q == $past(ptr_ld_addr));

  // R9
  split_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ptr_ld && byte_mode && lay_q == LAYOUT_SPLIT) |=> $stable(ptr_q));

  // R10
  pair_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ptr_ld && byte_mode && lay_q == LAYOUT_PAIRED)
      |=> (ptr_q[0] != $past(ptr_q[0])) && (ptr_q[ADDR_W-1:1] == $past(ptr_q[ADDR_W-1:1])));

  // R7
  paired_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !ptr_ld && !byte_mode && lay_q == LAYOUT_PAIRED
      && ptr_q == ADDR_W'(LAST_PAIRED)) |=> ptr_q == '0);

  // R11
  layout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !ptr_ld |=> $stable(lay_q));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ptr_ld && !byte_done) |=> $stable(ptr_q) && $stable(reg_idx) && $stable(reg_hit));

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_hit |-> reg_idx == '0);
endmodule

// File: tb/reg_ptr_top_tb.sv
module reg_ptr_top_tb;
  localparam int AW = 5;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ptr_ld = 1'b0;
  logic [AW-1:0] ptr_ld_addr = '0;
  logic          byte_done = 1'b0;
  logic          layout_in = 1'b0;
  logic          byte_mode = 1'b0;
  logic [AW-1:0] ptr_q;
  logic [IW-1:0] reg_idx;
  logic          reg_hit;

  int errs = 0;
  int checks = 0;
  int mp = 0;
  int mb = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reg_ptr_top u_dut (
    .clk(clk), .rst(rst), .ptr_ld(ptr_ld), .ptr_ld_addr(ptr_ld_addr),
    .byte_done(byte_done), .layout_in(layout_in), .byte_mode(byte_mode),
    .ptr_q(ptr_q), .reg_idx(reg_idx), .reg_hit(reg_hit)
  );

  function automatic int exp_hit(int a, int b);
    if (b == 0) return (a < 22) ? 1 : 0;
    return ((a % 16) < 11) ? 1 : 0;
  endfunction

  function automatic int exp_idx(int a, int b);
    if (exp_hit(a, b) == 0) return 0;
    if (b == 0) return a;
    return (a < 16) ? 2 * a : 2 * (a - 16) + 1;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, int'(ptr_q), mp);
    chk(req, int'(reg_idx), exp_idx(mp, mb));
    chk(req, int'(reg_hit), exp_hit(mp, mb));
  endtask

  task automatic model_step(int bm);
    int last;
    if (bm != 0) begin
      if (mb == 0) mp = mp ^ 1;
    end else begin
      last = (mb != 0) ? 26 : 21;
      mp = (mp >= last) ? 0 : mp + 1;
    end
  endtask

  task automatic do_load(int a, int b);
    ptr_ld = 1'b1; ptr_ld_addr = AW'(a); layout_in = b[0];
    @(negedge clk);
    ptr_ld = 1'b0;
    mp = a; mb = b;
  endtask

  task automatic do_step(int bm, int lay);
    byte_done = 1'b1; byte_mode = bm[0]; layout_in = lay[0];
    @(negedge clk);
    byte_done = 1'b0;
    model_step(bm);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_all("R1");

    // R3 R4 R5 full sweep of addresses in both layouts
    for (int b = 0; b < 2; b++) begin
      for (int a = 0; a < 32; a++) begin
        do_load(a, b);
        chk_all(b == 0 ? "R3/R5 paired sweep" : "R4/R5 split sweep");
      end
    end

    // R6 configuration pair in both layouts
    do_load(10, 0); chk("R6", int'(reg_idx), 10);
    do_load(11, 0); chk("R6", int'(reg_idx), 11);
    do_load(5, 1);  chk("R6", int'(reg_idx), 10);
    do_load(21, 1); chk("R6", int'(reg_idx), 11);
    do_load(18, 0); chk("R3 example", int'(reg_idx), 18);

    // R7 sequential walk, paired, more than one lap
    do_load(0, 0);
    for (int i = 0; i < 30; i++) begin
      do_step(0, 0);
      chk_all("R7 paired sequential");
    end
    do_load(30, 0); do_step(0, 0); chk_all("R7 wrap from empty address");

    // R8 sequential walk, split, more than one lap
    do_load(0, 1);
    for (int i = 0; i < 32; i++) begin
      do_step(0, 1);
      chk_all("R8 split sequential");
    end

    // R9 hold, R10 swap from several starting points
    for (int s = 0; s < 4; s++) begin
      do_load(s * 7, 1);
      for (int i = 0; i < 3; i++) begin
        do_step(1, 1);
        chk_all("R9 split hold");
      end
      do_load(s * 5 + 1, 0);
      for (int i = 0; i < 3; i++) begin
        do_step(1, 0);
        chk_all("R10 paired swap");
      end
    end
    do_load(18, 0); do_step(1, 0); chk("R10 from A", int'(ptr_q), 19);
    do_step(1, 0); chk("R10 back to A", int'(ptr_q), 18);

    // R11 layout change mid-burst is ignored until load
    do_load(9, 0);
    do_step(0, 1); chk_all("R11 layout ignored mid-burst");
    chk("R11", int'(reg_idx), 10);
    do_step(1, 1); chk("R11 still swapping", int'(ptr_q), 11);
    do_load(5, 1); do_step(1, 0); chk_all("R11 split after load holds");

    // R2 load wins over strobe
    do_load(3, 0);
    ptr_ld = 1'b1; ptr_ld_addr = AW'(17); layout_in = 1'b1;
    byte_done = 1'b1; byte_mode = 1'b0;
    @(negedge clk);
    ptr_ld = 1'b0; byte_done = 1'b0;
    mp = 17; mb = 1;
    chk_all("R2 load beats strobe");
    chk("R2 index", int'(reg_idx), 3);

    // R13 idle cycles hold
    layout_in = 1'b0; byte_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R13 idle hold");

    // R12 mode switching within a burst
    do_load(4, 0);
    do_step(0, 0); chk_all("R12 count");
    do_step(1, 0); chk_all("R12 swap");
    do_step(0, 0); chk_all("R12 count again");
    chk("R12", int'(ptr_q), 5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule